// File: doc/BRIEF.md
# Dual-Edge Strobe Sampler with Gated Data Capture

This block takes a data vector and an asynchronous write strobe, both from outside the clock domain, and moves them into the rising-edge domain of the system clock. Two flops sample the strobe: one on the rising clock edge and one on the falling edge. A pulse that is at least half a clock period wide is therefore caught by at least one of them. Each sample then passes through a settling flop. For the falling-edge path, that flop gives half a clock period for a metastable first stage to resolve. The two settled samples are merged. A parameter adds further rising-edge stages for more margin.

The merged, synchronised strobe is edge-detected. Its rising edge becomes the clock enable of the data register. The data vector is never synchronised itself: it is loaded once, at a known edge, while the sender holds it stable. On that same edge a one-cycle valid pulse is raised, so every strobe gives exactly one capture.

The sender must keep the data bus stable from the assertion of the strobe until the capture edge. A strobe must be at least half a clock period wide. The gap between strobes must be at least three clock periods, counted from the fall of one strobe to the rise of the next.

Top module: `strobe_capture`

## Requirements
- R1: A strobe that is high at a rising clock edge is taken up by the rising-edge sampler. Its merged, settled sample is high two rising edges later.
- R2: A strobe pulse of at least half a period that is high only across a falling edge, and low at every rising edge, still produces a capture and a valid pulse.
- R3: On the capture edge, `cap_data_o` takes the value that `wr_data_i` has while the strobe is high.
- R4: With EXTRA_STAGES extra stages, `cap_valid_o` rises on a fixed rising edge after the strobe's rise. It is edge number 2+EXTRA_STAGES when the strobe rises in the first half of the clock period, and edge number 3+EXTRA_STAGES when it rises in the second half.
- R5: Each strobe gives exactly one `cap_valid_o` pulse, and that pulse is one clock cycle wide.
- R6: `cap_data_o` changes only on a cycle in which `cap_valid_o` is high. Changes on `wr_data_i` while the strobe is low leave it unchanged.
- R7: While `rst_ni` is low, `cap_valid_o` and `cap_data_o` are 0. They clear at once when reset is asserted, without waiting for a clock edge. Reset is released on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both of its edges are used for sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | Asynchronous write strobe, active high |
| wr_data_i | input | DATA_W | Data vector, held stable by the sender while the strobe is high |
| cap_data_o | output | DATA_W | Last captured data vector |
| cap_valid_o | output | 1 | One-cycle pulse, high in the cycle after a capture |

## Verification
The rising-edge and falling-edge samplers can both see the same strobe. A strobe that rises late in the period is taken by the rising-edge flop and then by the falling-edge flop half a period later, and the two paths must merge into one capture, not two. The bench provokes this by sweeping the rise of the strobe across ten phase points of the clock period, at three pulse widths. The narrowest width leaves some pulses visible to only one edge; the wider ones are seen by both. Each strobe is judged on its valid-pulse count being exactly one, on the captured value, and on the edge where the valid pulse appears, which is predicted from the phase.

// File: rtl/scap_pkg.sv
`timescale 1ns/1ps
package scap_pkg;
  // Pair of settled strobe samples, one from each clock edge path.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;

  // Number of flops in the reset-release synchroniser.
  localparam int unsigned RST_SYNC_DEPTH = 2;
endpackage

// File: rtl/scap_reset_sync.sv
`timescale 1ns/1ps
module scap_reset_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  // Assertion is asynchronous; release walks through the chain.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[DEPTH-1];
endmodule

// File: rtl/scap_dual_sampler.sv
`timescale 1ns/1ps
module scap_dual_sampler
  import scap_pkg::*;
#(
  parameter int unsigned EXTRA_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic sync_o
);
  localparam int unsigned CHAIN_LEN = EXTRA_STAGES + 1;

  logic       rise_q;
  logic       fall_q;
  edge_pair_t settle_d;
  edge_pair_t settle_q;
  logic       merged;
  logic [CHAIN_LEN-1:0] chain;

  // First stage on the rising edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
    end else begin
      rise_q <= stb_i;
    end
  end

  // First stage on the falling edge.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= stb_i;
    end
  end

  // Settling stage, both paths brought onto the rising edge.
  always_comb begin
    settle_d.rise = rise_q;
    settle_d.fall = fall_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
    end else begin
      settle_q <= settle_d;
    end
  end

  assign merged   = settle_q.rise | settle_q.fall;
  assign chain[0] = merged;

  // Optional extra synchroniser stages.
  for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_extra
    logic stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= 1'b0;
      end else begin
        stage_q <= chain[g-1];
      end
    end
    assign chain[g] = stage_q;
  end

  assign sync_o = chain[CHAIN_LEN-1];

  // Cycles since reset release, saturating, for the look-back below.
  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= 2'd0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 2'd1;
    end
  end

  AST_RISE_PATH_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) && $past(stb_i, 2) |-> merged); // R1
endmodule

// File: rtl/scap_pulse_gen.sv
`timescale 1ns/1ps
module scap_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic cap_en_o,
  output logic valid_o
);
  logic prev_q;
  logic valid_q;
  logic valid_d;

  always_comb begin
    cap_en_o = sync_i & ~prev_q;
    valid_d  = cap_en_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  AST_ROSE_GIVES_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_i) |=> valid_o); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
endmodule

// File: rtl/strobe_capture.sv
`timescale 1ns/1ps
module strobe_capture
  import scap_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned EXTRA_STAGES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] cap_data_o,
  output logic              cap_valid_o
);
  logic              rst_sync_n;
  logic              stb_sync;
  logic              cap_en;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;

  scap_reset_sync #(.DEPTH(RST_SYNC_DEPTH)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  scap_dual_sampler #(.EXTRA_STAGES(EXTRA_STAGES)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .stb_i  (wr_stb_i),
    .sync_o (stb_sync)
  );

  scap_pulse_gen u_pls (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sync_i   (stb_sync),
    .cap_en_o (cap_en),
    .valid_o  (cap_valid_o)
  );

  // Data register loaded only through the synchronised enable.
  always_comb begin
    data_d = cap_en ? wr_data_i : data_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign cap_data_o = data_q;

  AST_DATA_ONLY_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !$stable(cap_data_o) |-> cap_valid_o); // R6
  AST_RESET_OUTPUTS: assert property (@(posedge clk_i)
    !rst_sync_n |-> (!cap_valid_o && cap_data_o == '0)); // R7
endmodule

// File: tb/strobe_capture_test.sv
`timescale 1ns/1ps
module strobe_capture_test;
  localparam real         CLK_P  = 10.0;
  localparam int unsigned DW     = 16;
  localparam int unsigned EXTRA  = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stb;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          vld;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  strobe_capture #(.DATA_W(DW), .EXTRA_STAGES(EXTRA)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_stb_i    (stb),
    .wr_data_i   (din),
    .cap_data_o  (dout),
    .cap_valid_o (vld)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic one_strobe(input real phase, input real width, input logic [DW-1:0] val);
    int first = 0;
    int cnt = 0;
    logic [DW-1:0] got = '0;
    int exp_first;
    bit fall_only;
    @(posedge clk);
    #(phase);
    din = val;
    stb = 1'b1;
    fork
      begin
        #(width);
        stb = 1'b0;
      end
      begin
        for (int i = 1; i <= 8; i++) begin
          @(posedge clk);
          #(CLK_P*0.3);
          if (vld) begin
            cnt++;
            if (first == 0) begin
              first = i;
              got = dout;
            end
          end
        end
      end
    join
    exp_first = (phase < CLK_P/2) ? 2 + EXTRA : 3 + EXTRA;
    fall_only = (phase < CLK_P/2) && (phase + width < CLK_P);
    if (fall_only) check("R2 pulse seen only by falling edge", cnt, 1);
    else           check("R5 one valid pulse per strobe", cnt, 1);
    check("R3 captured value", got, val);
    check("R4 valid latency in rising edges", first, exp_first);
    // R6: bus changes while strobe is low must not reach the output
    din = ~val;
    repeat (3) @(posedge clk);
    #(CLK_P*0.3);
    check("R6 output held", dout, val);
    check("R6 no extra valid", vld, 0);
  endtask

  initial begin
    #(CLK_P*200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    stb   = 1'b0;
    din   = '0;
    repeat (3) @(posedge clk);
    #(CLK_P*0.3);
    check("R7 reset valid", vld, 0);
    check("R7 reset data", dout, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int w = 0; w < 3; w++) begin
      for (int p = 0; p < 10; p++) begin
        one_strobe(p + 0.5, 6.0 + 8.0*w,
                   DW'((w * 16'h1111 + p * 16'h0203) ^ 16'hA5C3));
      end
    end

    // R7: asynchronous clear in mid-cycle
    @(posedge clk);
    #(CLK_P*0.2);
    rst_n = 1'b0;
    #1;
    check("R7 async clear valid", vld, 0);
    check("R7 async clear data", dout, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    one_strobe(7.5, 6.0, 16'h3C5A);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule